// File: doc/BRIEF.md
# Command Frame Parser

The parser reads back a host command frame that a serial receiver has already placed in a word-wide RAM. When the receiver reports that the transfer is complete, the parser reads the RAM one word per clock, starting at address zero. The first two words are a fixed synchronisation pattern. If either word is wrong, reading stops and the frame is rejected.

The upper byte of the third word is the command. Its top bit selects one of two actions. In store mode, a two-bit area index is taken from the command. A fixed-length block of user waveform words is then streamed out with a strobe so that a storage writer can place it in one of four user areas. The block must be followed by a two-word terminator. In generate mode, a waveform type code is taken from the command. The next four words then supply the 32-bit frequency word (high half first), the amplitude and the phase (for a square wave the phase is the duty cycle). All four are published together with a one-cycle strobe.

Every frame ends with exactly one outcome pulse: parameters ready, store complete, header error, command error or terminator error.

Top module: `frame_parser`

## Requirements
- R1: A `start` pulse while idle begins reading at address 0, one read per clock at consecutive addresses. A `start` pulse while busy has no effect on the address sequence or on the result of the frame in progress.
- R2: If word 0 is not 0xAAF0 or word 1 is not 0xBB55, `hdr_err` pulses for one cycle and reading stops. No more than three reads are issued for such a frame, and no data or parameter strobe is produced.
- R3: Word 2 bit 15 = 1 selects store mode and sets `mode` to 1. Bits 14:8 give the area. Values 0 to 3 select user areas 1 to 4 and appear on `area` as 0 to 3. Any other value pulses `cmd_err`.
- R4: Word 2 bit 15 = 0 selects generate mode and sets `mode` to 0. Bits 14:11 give the type code: 1 sine, 2 square, 3 triangle, 4 sawtooth, 5 noise, 6 to 9 user areas 1 to 4. Codes 0 and 10 to 15 pulse `cmd_err`.
- R5: In generate mode, words 3 to 6 are the frequency high half, the frequency low half, the amplitude and the phase. They appear on `freq_word`, `amp_word`, `phase_word` and `wave_type` with a one-cycle `params_valid` pulse. These outputs do not change at any other time.
- R6: In store mode, exactly STORE_LEN words, taken from word 3 onward, are presented in address order on `store_data`, each with a one-cycle `store_valid`.
- R7: If the two words after the data block are 0x6580 and then 0x0856, `store_done` pulses once and the parser returns to idle.
- R8: If either terminator word differs, `term_err` pulses and `store_done` is not asserted for that frame.
- R9: After reset the parser is idle: `busy` and `rd_en` are low and all strobes are low.
- R10: Each frame produces exactly one of `params_valid`, `store_done`, `hdr_err`, `cmd_err` or `term_err`, and never two of them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Host transfer complete pulse |
| rd_en | output | 1 | RAM read request |
| rd_addr | output | AW | RAM read address |
| rd_data | input | 16 | RAM read data, valid one clock after `rd_en` |
| busy | output | 1 | Frame being parsed |
| mode | output | 1 | 1 = store, 0 = generate |
| wave_type | output | 4 | Waveform type code |
| freq_word | output | 32 | Frequency word |
| amp_word | output | 16 | Amplitude word |
| phase_word | output | 16 | Phase / duty word |
| params_valid | output | 1 | Generation parameters updated |
| area | output | 2 | User storage area index |
| store_data | output | 16 | User waveform word |
| store_valid | output | 1 | `store_data` strobe |
| store_done | output | 1 | Store frame terminated correctly |
| hdr_err | output | 1 | Header mismatch |
| cmd_err | output | 1 | Illegal type or area code |
| term_err | output | 1 | Terminator missing |

## Verification
A word counter that is off by one shows up at once. The data block gets one word too many or too few, the terminator is compared against a data word, and the frame ends in `term_err` rather than `store_done`. A state that goes wrong during the header or the command shows up within a clock or two: either the wrong outcome pulse fires, or the read address runs past the point where it should stop. Wrong routing of parameter words can only be seen when `params_valid` pulses, so every generate frame compares all four values against the words the bench placed in RAM.

// File: rtl/frame_parser.sv
module frame_parser #(
  parameter int AW        = 18,
  parameter int STORE_LEN = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  output logic          busy,
  output logic          mode,
  output logic [3:0]    wave_type,
  output logic [31:0]   freq_word,
  output logic [15:0]   amp_word,
  output logic [15:0]   phase_word,
  output logic          params_valid,
  output logic [1:0]    area,
  output logic [15:0]   store_data,
  output logic          store_valid,
  output logic          store_done,
  output logic          hdr_err,
  output logic          cmd_err,
  output logic          term_err
);
  localparam int CW = $clog2(STORE_LEN) + 2;
  localparam logic [CW-1:0] LAST = CW'(STORE_LEN - 1);
  localparam logic [15:0] SYNC0 = 16'hAAF0;
  localparam logic [15:0] SYNC1 = 16'hBB55;
  localparam logic [15:0] END0  = 16'h6580;
  localparam logic [15:0] END1  = 16'h0856;

  typedef enum logic [2:0] {IDLE, HDR0, HDR1, CMD, STORE, TERM0, TERM1, PARAM} st_t;

  st_t           st;
  logic          pend;
  logic [CW-1:0] cnt;
  logic [15:0]   fhi, flo, amp_r;
  logic [3:0]    type_r;

  assign busy  = (st != IDLE);
  assign rd_en = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; pend <= 1'b0; cnt <= '0; rd_addr <= '0;
      fhi <= '0; flo <= '0; amp_r <= '0; type_r <= '0;
      mode <= 1'b0; wave_type <= '0; freq_word <= '0; amp_word <= '0; phase_word <= '0;
      area <= '0; store_data <= '0;
      params_valid <= 1'b0; store_valid <= 1'b0; store_done <= 1'b0;
      hdr_err <= 1'b0; cmd_err <= 1'b0; term_err <= 1'b0;
    end else begin
      params_valid <= 1'b0; store_valid <= 1'b0; store_done <= 1'b0;
      hdr_err <= 1'b0; cmd_err <= 1'b0; term_err <= 1'b0;
      pend <= rd_en;
      rd_addr <= busy ? rd_addr + 1'b1 : '0;
      case (st)
        IDLE: if (start) st <= HDR0;
        HDR0: if (pend) begin
          if (rd_data == SYNC0) st <= HDR1;
          else begin hdr_err <= 1'b1; st <= IDLE; end
        end
        HDR1: if (pend) begin
          if (rd_data == SYNC1) st <= CMD;
          else begin hdr_err <= 1'b1; st <= IDLE; end
        end
        CMD: if (pend) begin
          cnt <= '0;
          if (rd_data[15]) begin
            if (|rd_data[14:10]) begin cmd_err <= 1'b1; st <= IDLE; end
            else begin mode <= 1'b1; area <= rd_data[9:8]; st <= STORE; end
          end else begin
            if (rd_data[14:11] >= 4'd1 && rd_data[14:11] <= 4'd9) begin
              mode <= 1'b0; type_r <= rd_data[14:11]; st <= PARAM;
            end else begin cmd_err <= 1'b1; st <= IDLE; end
          end
        end
        STORE: if (pend) begin
          store_valid <= 1'b1;
          store_data  <= rd_data;
          if (cnt == LAST) st <= TERM0;
          else cnt <= cnt + 1'b1;
        end
        TERM0: if (pend) begin
          if (rd_data == END0) st <= TERM1;
          else begin term_err <= 1'b1; st <= IDLE; end
        end
        TERM1: if (pend) begin
          if (rd_data == END1) store_done <= 1'b1;
          else term_err <= 1'b1;
          st <= IDLE;
        end
        PARAM: if (pend) begin
          cnt <= cnt + 1'b1;
          case (cnt[1:0])
            2'd0: fhi <= rd_data;
            2'd1: flo <= rd_data;
            2'd2: amp_r <= rd_data;
            default: begin
              freq_word <= {fhi, flo};
              amp_word <= amp_r;
              phase_word <= rd_data;
              wave_type <= type_r;
              params_valid <= 1'b1;
              st <= IDLE;
            end
          endcase
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module frame_parser_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          mode,
  input logic [31:0]   freq_word,
  input logic [15:0]   amp_word,
  input logic [15:0]   phase_word,
  input logic          params_valid,
  input logic          store_valid,
  input logic          store_done,
  input logic          hdr_err,
  input logic          cmd_err,
  input logic          term_err
);
  a_r1_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> rd_addr == '0);
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1);
  a_r2_hdr_stop: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !busy);
  a_r5_param_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !params_valid |-> $stable(freq_word) && $stable(amp_word) && $stable(phase_word));
  a_r6_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid |-> busy && mode);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |-> !busy && mode);
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({params_valid, store_done, hdr_err, cmd_err, term_err}) <= 1);
endmodule

bind frame_parser frame_parser_chk #(.AW(AW)) u_chk (.*);

// File: tb/frame_parser_bench.sv
module frame_parser_bench;
  localparam int AW = 18;
  localparam int SL = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic rd_en, busy, mode, params_valid, store_valid, store_done, hdr_err, cmd_err, term_err;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data = '0, amp_word, phase_word, store_data;
  logic [3:0] wave_type;
  logic [31:0] freq_word;
  logic [1:0] area;

  frame_parser #(.AW(AW), .STORE_LEN(SL)) u_frame_parser (.*);

  always #5 clk = ~clk;

  logic [15:0] mem [0:63];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[5:0]];

  int total = 0, bad = 0;
  int n_pv = 0, n_done = 0, n_hdr = 0, n_cmd = 0, n_term = 0, n_rd = 0, n_cap = 0, addr_bad = 0;
  logic [15:0] cap [0:1023];
  logic rd_prev = 0;
  logic [AW-1:0] last_addr = '0;

  always @(negedge clk) if (rst_n) begin
    if (rd_en) begin
      n_rd++;
      if (!rd_prev && rd_addr != '0) addr_bad++;
      if (rd_prev && rd_addr != last_addr + 1'b1) addr_bad++;
      last_addr = rd_addr;
    end
    rd_prev = rd_en;
    if (store_valid) begin cap[n_cap % 1024] = store_data; n_cap++; end
    if (params_valid) n_pv++;
    if (store_done) n_done++;
    if (hdr_err) n_hdr++;
    if (cmd_err) n_cmd++;
    if (term_err) n_term++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic int model_outcome();
    logic [15:0] c;
    if (mem[0] != 16'hAAF0 || mem[1] != 16'hBB55) return 2;
    c = mem[2];
    if (c[15]) begin
      if (c[14:8] > 7'd3) return 3;
      if (mem[3+SL] != 16'h6580 || mem[4+SL] != 16'h0856) return 4;
      return 1;
    end
    if (c[14:11] >= 4'd1 && c[14:11] <= 4'd9) return 0;
    return 3;
  endfunction

  task automatic mk_gen(input logic [3:0] t);
    mem[0] = 16'hAAF0; mem[1] = 16'hBB55;
    mem[2] = {1'b0, t, 11'($urandom)};
    for (int i = 3; i < 64; i++) mem[i] = 16'($urandom);
  endtask

  task automatic mk_store(input logic [6:0] ar, input bit g0, input bit g1);
    mem[0] = 16'hAAF0; mem[1] = 16'hBB55;
    mem[2] = {1'b1, ar, 8'($urandom)};
    for (int i = 3; i < 64; i++) mem[i] = 16'($urandom);
    mem[3+SL] = g0 ? 16'h6580 : 16'h6581;
    mem[4+SL] = g1 ? 16'h0856 : 16'h0857;
  endtask

  task automatic run(input bit restart_mid);
    int b_pv, b_done, b_hdr, b_cmd, b_term, b_rd, b_cap, exp_o;
    logic [15:0] c;
    b_pv = n_pv; b_done = n_done; b_hdr = n_hdr; b_cmd = n_cmd; b_term = n_term;
    b_rd = n_rd; b_cap = n_cap;
    exp_o = model_outcome();
    c = mem[2];
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (restart_mid) begin repeat (3) @(negedge clk); start = 1; @(negedge clk) start = 0; end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    // R10: exactly one outcome
    chk((n_pv-b_pv)+(n_done-b_done)+(n_hdr-b_hdr)+(n_cmd-b_cmd)+(n_term-b_term) == 1,
        "R10 outcome count", (n_pv-b_pv)+(n_done-b_done)+(n_hdr-b_hdr)+(n_cmd-b_cmd)+(n_term-b_term), 1);
    case (exp_o)
      0: begin
        chk(n_pv - b_pv == 1, "R4 params_valid", n_pv - b_pv, 1);
        chk(freq_word == {mem[3], mem[4]}, "R5 freq", freq_word, {mem[3], mem[4]});
        chk(amp_word == mem[5] && phase_word == mem[6], "R5 amp/phase",
            {amp_word, phase_word}, {mem[5], mem[6]});
        chk(wave_type == c[14:11] && mode == 0, "R4 type/mode", {mode, wave_type}, {1'b0, c[14:11]});
      end
      1, 4: begin
        if (exp_o == 1) chk(n_done - b_done == 1, "R7 store_done", n_done - b_done, 1);
        else chk(n_term - b_term == 1 && n_done == b_done, "R8 term_err", n_term - b_term, 1);
        chk(n_cap - b_cap == SL, "R6 word count", n_cap - b_cap, SL);
        for (int i = 0; i < SL; i++)
          if (cap[(b_cap + i) % 1024] != mem[3+i])
            chk(0, "R6 store word", cap[(b_cap + i) % 1024], mem[3+i]);
        chk(area == c[9:8] && mode == 1, "R3 area/mode", {mode, area}, {1'b1, c[9:8]});
      end
      2: begin
        chk(n_hdr - b_hdr == 1, "R2 hdr_err", n_hdr - b_hdr, 1);
        chk(n_rd - b_rd <= 3 && n_cap == b_cap, "R2 reads stop", n_rd - b_rd, 3);
      end
      default: begin
        chk(n_cmd - b_cmd == 1, "R3 R4 cmd_err", n_cmd - b_cmd, 1);
        chk(n_cap == b_cap, "R3 no store data", n_cap - b_cap, 0);
      end
    endcase
    chk(addr_bad == 0, "R1 address sequence", addr_bad, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_en && !params_valid && !store_valid && !store_done &&
        !hdr_err && !cmd_err && !term_err, "R9 reset state", {busy, rd_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_en, "R9 idle after reset", {busy, rd_en}, 0);

    mk_gen(4'd1); mem[0] = 16'hAAF1; run(0);
    mk_gen(4'd2); mem[1] = 16'hBB54; run(0);
    mk_gen(4'd0); run(0);
    mk_gen(4'd10); run(0);
    mk_gen(4'd9); run(0);
    mk_gen(4'd2); run(1);
    for (int a = 0; a < 4; a++) begin mk_store(7'(a), 1, 1); run(0); end
    mk_store(7'd4, 1, 1); run(0);
    mk_store(7'd1, 0, 1); run(0);
    mk_store(7'd2, 1, 0); run(0);
    mk_store(7'd3, 1, 1); run(1);

    for (int k = 0; k < 20; k++) begin
      if ($urandom_range(1, 0) == 1) mk_gen(4'($urandom_range(15, 0)));
      else mk_store(7'($urandom_range(5, 0)), $urandom_range(7, 0) != 0, $urandom_range(7, 0) != 0);
      if ($urandom_range(9, 0) == 0) mem[$urandom_range(1, 0)] ^= 16'h0010;
      run(0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule